// File: doc/BRIEF.md
# Bit-Plane / Colour-Index Pattern Store

This block keeps an eight-plane drawing pattern, one 32-bit row per plane, behind a small byte-addressed register window. Software may treat the same storage in either of two shapes. In the row shape each access reaches one whole plane row. In the colour shape each access reaches one pixel column: a read collects the bit of that column from every plane into an 8-bit colour index, and a write spreads an 8-bit colour index back across the planes.

A single view bit, held at bit 15 of a control word, chooses the shape. Accesses are 8, 16 or 32 bits wide. Reads return data on `rd_data` one clock after the request, together with a one-cycle `rd_valid` pulse. Writes take effect at the clock edge that accepts them, so a read issued on the next cycle already sees the new contents.

Window layout: the pattern area spans byte offsets 0x00 to 0x7F, and the control word sits at offset 0x80. In the row shape, plane k sits at offset 4k. In the colour shape, pixel n sits at offset 4n. Plane k always supplies bit k of a colour index.

Top module: `ptx_transposer`

## Requirements
- R1: After reset every plane row is zero and the view bit is 0 (row shape). Every read returns 0 until something is written.
- R2: The control word sits at offset 0x80. A 16- or 32-bit write copies write-data bit 15 into the view bit, and a 16- or 32-bit read returns the view bit at bit 15 with all other bits zero. An 8-bit read of it returns 0, and an 8-bit write to it leaves the view bit unchanged.
- R3: With view 0, a read at offset 4k with k < 8 returns the low 8, 16 or 32 bits of plane k, according to the access width (size code 0, 1 or 2), with the higher bits zero.
- R4: With view 0, a write at offset 4k with k < 8 replaces the low 8, 16 or 32 bits of plane k with the same bits of the write data. The higher bits of that plane and all other planes are unchanged.
- R5: With view 1, a read at offset 4n returns a value whose bit i equals bit n of plane i, for i = 0..7, with bits 31:8 zero.
- R6: With view 1, a write at offset 4n stores write-data bit i into bit n of plane i for all eight planes at one clock edge, and leaves every other stored bit unchanged.
- R7: With view 1, 8- and 16-bit accesses reach pixels 0..15 and 32-bit accesses reach pixels 0..31. An access beyond that range reads 0 and its write is ignored.
- R8: An offset that is not a multiple of 4 reads 0 and its write is ignored. So does a row-shape offset of 0x20 or above, and any offset above 0x80.
- R9: `rd_valid` is high exactly in the cycle after a read request and low after a write request or an idle cycle. `rd_data` then holds the value for that request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit |
| acc_offset | input | 8 | Byte offset in the window |
| acc_wdata | input | 32 | Write data, little-endian, low bits used for narrow widths |
| rd_data | output | 32 | Read result, valid with rd_valid |
| rd_valid | output | 1 | Pulses one cycle after a read request |

## Verification
The assertions assume that `acc_offset`, `acc_size` and `acc_write` are known whenever `acc_valid` is high. They also assume that no access arrives during reset, so every property starts from a cleared store. The bench drives all request fields at the falling edge from fully defined random values. It issues one request at a time and leaves an idle cycle after each, so each read result is sampled cleanly. Its random offsets are mostly aligned within 0x00 to 0x84 and sometimes arbitrary bytes, which exercises both shapes, the control word and the rejected offsets.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

  localparam int PTX_PLANES = 8;
  localparam int PTX_ROW    = 32;
  localparam int PTX_IDX_W  = $clog2(PTX_ROW);
  localparam int PTX_PSEL_W = $clog2(PTX_PLANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } acc_size_e;

  typedef logic [PTX_PLANES-1:0][PTX_ROW-1:0] rows_t;

  // Byte lanes touched by an access of the given width.
  function automatic logic [PTX_ROW-1:0] ptx_size_mask(input logic [1:0] sz);
    logic [PTX_ROW-1:0] m;
    m = '0;
    case (acc_size_e'(sz))
      SZ_BYTE: m[7:0]  = '1;
      SZ_HALF: m[15:0] = '1;
      default: m       = '1;
    endcase
    return m;
  endfunction

  // Replace masked bits of a row.
  function automatic logic [PTX_ROW-1:0] ptx_merge(input logic [PTX_ROW-1:0] old_v,
                                                   input logic [PTX_ROW-1:0] new_v,
                                                   input logic [PTX_ROW-1:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction

  // Collect one column across all planes into a colour index.
  function automatic logic [PTX_PLANES-1:0] ptx_gather(input rows_t rows,
                                                       input logic [PTX_IDX_W-1:0] col);
    logic [PTX_PLANES-1:0] c;
    for (int p = 0; p < PTX_PLANES; p++) c[p] = rows[p][col];
    return c;
  endfunction

endpackage

// File: rtl/ptx_decode.sv
module ptx_decode
  import ptx_pkg::*;
#(
  parameter int NP          = PTX_PLANES,
  parameter int RB          = PTX_ROW,
  parameter int OFF_W       = 8,
  parameter int CTRL_OFFSET = 'h80
) (
  input  logic [OFF_W-1:0]           offset,
  input  logic [1:0]                 size,
  input  logic                       view_pixel,
  output logic                       ctrl_hit,
  output logic                       pat_hit,
  output logic [$clog2(RB)-1:0]      idx
);
  localparam int SLOT_W = OFF_W - 2;
  localparam int IDX_W  = $clog2(RB);
  localparam logic [SLOT_W-1:0] PLANE_LIM = SLOT_W'(NP);
  localparam logic [SLOT_W-1:0] WIDE_LIM  = SLOT_W'(RB);
  localparam logic [SLOT_W-1:0] NARR_LIM  = SLOT_W'(RB / 2);

  logic              aligned;
  logic [SLOT_W-1:0] slot;
  logic              wide;
  logic [SLOT_W-1:0] pix_lim;

  always_comb begin
    aligned  = (offset[1:0] == 2'b00);
    slot     = offset[OFF_W-1:2];
    wide     = size[1];
    pix_lim  = wide ? WIDE_LIM : NARR_LIM;
    ctrl_hit = (offset == OFF_W'(CTRL_OFFSET));
    if (view_pixel) pat_hit = aligned && (slot < pix_lim);
    else            pat_hit = aligned && (slot < PLANE_LIM);
    idx      = slot[IDX_W-1:0];
  end
endmodule

// File: rtl/ptx_plane_file.sv
module ptx_plane_file
  import ptx_pkg::*;
#(
  parameter int NP = PTX_PLANES,
  parameter int RB = PTX_ROW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    row_we,
  input  logic [$clog2(NP)-1:0]   row_sel,
  input  logic [RB-1:0]           row_wdata,
  input  logic [RB-1:0]           row_mask,
  input  logic                    pix_we,
  input  logic [$clog2(RB)-1:0]   pix_col,
  input  logic [NP-1:0]           pix_color,
  output logic [NP-1:0][RB-1:0]   rows
);
  for (genvar p = 0; p < NP; p++) begin : g_plane
    logic [RB-1:0] row_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        row_q <= '0;
      end else if (row_we && (row_sel == p[$clog2(NP)-1:0])) begin
        row_q <= (row_q & ~row_mask) | (row_wdata & row_mask);
      end else if (pix_we) begin
        row_q[pix_col] <= pix_color[p];
      end
    end
    assign rows[p] = row_q;
  end
endmodule

// File: rtl/ptx_read_mux.sv
module ptx_read_mux
  import ptx_pkg::*;
#(
  parameter int NP       = PTX_PLANES,
  parameter int RB       = PTX_ROW,
  parameter int VIEW_BIT = 15
) (
  input  logic [NP-1:0][RB-1:0]   rows,
  input  logic                    view_pixel,
  input  logic                    ctrl_hit,
  input  logic                    pat_hit,
  input  logic [$clog2(RB)-1:0]   idx,
  input  logic [1:0]              size,
  output logic [RB-1:0]           rd_next
);
  localparam int PSEL_W = $clog2(NP);

  always_comb begin
    rd_next = '0;
    if (ctrl_hit) begin
      if (acc_size_e'(size) != SZ_BYTE) rd_next[VIEW_BIT] = view_pixel;
    end else if (pat_hit) begin
      if (view_pixel) rd_next[NP-1:0] = ptx_gather(rows, idx);
      else            rd_next = rows[idx[PSEL_W-1:0]] & ptx_size_mask(size);
    end
  end
endmodule

// File: rtl/ptx_transposer.sv
module ptx_transposer
  import ptx_pkg::*;
#(
  parameter int NP          = PTX_PLANES,
  parameter int RB          = PTX_ROW,
  parameter int OFF_W       = 8,
  parameter int CTRL_OFFSET = 'h80,
  parameter int VIEW_BIT    = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [1:0]       acc_size,
  input  logic [OFF_W-1:0] acc_offset,
  input  logic [RB-1:0]    acc_wdata,
  output logic [RB-1:0]    rd_data,
  output logic             rd_valid
);
  localparam int IDX_W  = $clog2(RB);
  localparam int PSEL_W = $clog2(NP);

  // Named internal events, observed by the bound checker.
  logic                  view_q;
  logic                  ctrl_hit;
  logic                  pat_hit;
  logic                  acc_miss;
  logic                  ctrl_wr;
  logic                  row_wr;
  logic                  pix_wr;
  logic                  pix_rd;
  logic [IDX_W-1:0]      pix_idx;
  logic [NP-1:0][RB-1:0] plane_rows;
  logic [RB-1:0]         rd_next;
  logic [RB-1:0]         rd_q;
  logic                  rd_v_q;

  ptx_decode #(.NP(NP), .RB(RB), .OFF_W(OFF_W), .CTRL_OFFSET(CTRL_OFFSET)) u_dec (
    .offset     (acc_offset),
    .size       (acc_size),
    .view_pixel (view_q),
    .ctrl_hit   (ctrl_hit),
    .pat_hit    (pat_hit),
    .idx        (pix_idx)
  );

  assign acc_miss = !ctrl_hit && !pat_hit;
  assign ctrl_wr  = acc_valid && acc_write && ctrl_hit && (acc_size != 2'd0);
  assign row_wr   = acc_valid && acc_write && pat_hit && !view_q;
  assign pix_wr   = acc_valid && acc_write && pat_hit && view_q;
  assign pix_rd   = acc_valid && !acc_write && pat_hit && view_q;

  ptx_plane_file #(.NP(NP), .RB(RB)) u_file (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_we    (row_wr),
    .row_sel   (pix_idx[PSEL_W-1:0]),
    .row_wdata (acc_wdata),
    .row_mask  (ptx_size_mask(acc_size)),
    .pix_we    (pix_wr),
    .pix_col   (pix_idx),
    .pix_color (acc_wdata[NP-1:0]),
    .rows      (plane_rows)
  );

  ptx_read_mux #(.NP(NP), .RB(RB), .VIEW_BIT(VIEW_BIT)) u_rd (
    .rows       (plane_rows),
    .view_pixel (view_q),
    .ctrl_hit   (ctrl_hit),
    .pat_hit    (pat_hit),
    .idx        (pix_idx),
    .size       (acc_size),
    .rd_next    (rd_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      view_q <= 1'b0;
      rd_q   <= '0;
      rd_v_q <= 1'b0;
    end else begin
      if (ctrl_wr) view_q <= acc_wdata[VIEW_BIT];
      rd_v_q <= acc_valid && !acc_write;
      if (acc_valid && !acc_write) rd_q <= rd_next;
    end
  end

  assign rd_data  = rd_q;
  assign rd_valid = rd_v_q;
endmodule

// File: rtl/ptx_transposer_chk.sv
module ptx_transposer_chk #(
  parameter int NP = 8,
  parameter int RB = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   acc_valid,
  input logic                   acc_write,
  input logic                   acc_miss,
  input logic                   ctrl_wr,
  input logic                   pix_wr,
  input logic                   pix_rd,
  input logic [$clog2(RB)-1:0]  pix_idx,
  input logic                   view_q,
  input logic [NP*RB-1:0]       rows_flat,
  input logic [RB-1:0]          rd_data,
  input logic                   rd_valid
);
  logic [NP*RB-1:0] col_mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) col_mask_q <= '0;
    else        col_mask_q <= {NP{RB'(1) << pix_idx}};
  end

  assert_rd_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |=> rd_valid);
  assert_rd_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && !acc_write) |=> !rd_valid);
  assert_miss_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_miss) |=> (rd_data == '0));
  assert_miss_write_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_miss) |=> ($stable(rows_flat) && $stable(view_q)));
  assert_view_only_by_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(view_q));
  assert_pix_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pix_rd |=> (rd_data[RB-1:NP] == '0));
  assert_pix_column_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pix_wr |=> (((rows_flat ^ $past(rows_flat)) & ~col_mask_q) == '0));
endmodule

bind ptx_transposer ptx_transposer_chk #(.NP(NP), .RB(RB)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_valid (acc_valid),
  .acc_write (acc_write),
  .acc_miss  (acc_miss),
  .ctrl_wr   (ctrl_wr),
  .pix_wr    (pix_wr),
  .pix_rd    (pix_rd),
  .pix_idx   (pix_idx),
  .view_q    (view_q),
  .rows_flat (plane_rows),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid)
);

// File: tb/ptx_transposer_tb.sv
`timescale 1ns/1ps
module ptx_transposer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [1:0]  acc_size = 2'd0;
  logic [7:0]  acc_offset = 8'd0;
  logic [31:0] acc_wdata = 32'd0;
  logic [31:0] rd_data;
  logic        rd_valid;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] m_rows [8];
  logic        m_view;

  always #4 clk = ~clk;

  ptx_transposer dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_size(acc_size), .acc_offset(acc_offset), .acc_wdata(acc_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic logic [31:0] wmask(input logic [1:0] sz);
    if (sz == 2'd0) return 32'h0000_00FF;
    if (sz == 2'd1) return 32'h0000_FFFF;
    return 32'hFFFF_FFFF;
  endfunction

  function automatic int pix_limit(input logic [1:0] sz);
    return (sz >= 2'd2) ? 32 : 16;
  endfunction

  function automatic logic [31:0] model_read(input logic [1:0] sz, input logic [7:0] off);
    logic [31:0] r;
    int n;
    r = 0;
    n = int'(off) / 4;
    if (off == 8'h80) begin
      if (sz != 2'd0) r[15] = m_view;
    end else if (off[1:0] == 2'b00 && off < 8'h80) begin
      if (!m_view) begin
        if (n < 8) r = m_rows[n] & wmask(sz);
      end else if (n < pix_limit(sz)) begin
        for (int p = 0; p < 8; p++) r[p] = m_rows[p][n];
      end
    end
    return r;
  endfunction

  task automatic model_write(input logic [1:0] sz, input logic [7:0] off, input logic [31:0] d);
    int n;
    n = int'(off) / 4;
    if (off == 8'h80) begin
      if (sz != 2'd0) m_view = d[15];
    end else if (off[1:0] == 2'b00 && off < 8'h80) begin
      if (!m_view) begin
        if (n < 8) m_rows[n] = (m_rows[n] & ~wmask(sz)) | (d & wmask(sz));
      end else if (n < pix_limit(sz)) begin
        for (int p = 0; p < 8; p++) m_rows[p][n] = d[p];
      end
    end
  endtask

  function automatic string tag_of(input logic [1:0] sz, input logic [7:0] off, input bit wr);
    int n;
    n = int'(off) / 4;
    if (off == 8'h80) return "R2";
    if (off[1:0] != 2'b00 || off > 8'h80) return "R8";
    if (!m_view) return (n < 8) ? (wr ? "R4" : "R3") : "R8";
    if (n >= pix_limit(sz)) return "R7";
    return wr ? "R6" : "R5";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] sz, input logic [7:0] off, input logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_size = sz; acc_offset = off; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0;
    model_write(sz, off, d);
    check("R9", {31'd0, rd_valid}, 32'd0);
  endtask

  task automatic do_read(input logic [1:0] sz, input logic [7:0] off, input string req);
    logic [31:0] exp;
    exp = model_read(sz, off);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_size = sz; acc_offset = off;
    acc_wdata = $urandom;
    @(negedge clk);
    acc_valid = 1'b0;
    check("R9", {31'd0, rd_valid}, 32'd1);
    check(req, rd_data, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    checks++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int p = 0; p < 8; p++) m_rows[p] = 32'd0;
    m_view = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: cleared after reset
    for (int p = 0; p < 8; p++) do_read(2'd2, 8'(p * 4), "R1");
    do_read(2'd2, 8'h80, "R1");

    // R4 / R3: narrow write keeps upper bits
    do_write(2'd2, 8'h0C, 32'hDEAD_BEEF);
    do_write(2'd0, 8'h0C, 32'h0000_0011);
    do_read(2'd2, 8'h0C, "R4");
    do_read(2'd1, 8'h0C, "R3");

    // R8: misaligned and out-of-range row offsets
    do_write(2'd2, 8'h0E, 32'hFFFF_FFFF);
    do_read(2'd2, 8'h0E, "R8");
    do_write(2'd2, 8'h20, 32'h1234_5678);
    do_read(2'd2, 8'h20, "R8");
    do_read(2'd2, 8'h0C, "R8");

    // R2: view select through control word
    do_write(2'd2, 8'h80, 32'h0000_8000);
    do_read(2'd1, 8'h80, "R2");
    do_read(2'd0, 8'h80, "R2");
    do_write(2'd0, 8'h80, 32'h0000_0000);
    do_read(2'd2, 8'h80, "R2");

    // R6 / R5: colour write at the last wide pixel
    do_write(2'd2, 8'h7C, 32'h0000_00A5);
    do_read(2'd2, 8'h7C, "R6");
    do_read(2'd1, 8'h0C, "R5");

    // R7: narrow access beyond pixel 15
    do_write(2'd1, 8'h40, 32'h0000_00FF);
    do_read(2'd1, 8'h40, "R7");
    do_read(2'd2, 8'h40, "R7");

    // back to rows: inspect planes at the ports (R6)
    do_write(2'd1, 8'h80, 32'h0000_0000);
    for (int p = 0; p < 8; p++) do_read(2'd2, 8'(p * 4), "R6");

    // random mix
    for (int i = 0; i < 1500; i++) begin
      int kind;
      logic [1:0] sz;
      logic [7:0] off;
      kind = int'($urandom_range(0, 99));
      sz   = 2'($urandom_range(0, 2));
      if ($urandom_range(0, 9) < 8) off = 8'($urandom_range(0, 33) * 4);
      else                          off = 8'($urandom_range(0, 255));
      if (kind < 8) begin
        do_write(2'($urandom_range(0, 2)), 8'h80, {16'd0, 1'($urandom_range(0, 1)), 15'd0});
      end else if (kind < 50) begin
        do_write(sz, off, $urandom);
      end else begin
        do_read(sz, off, tag_of(sz, off, 1'b0));
      end
    end

    // final sweep through rows
    do_write(2'd2, 8'h80, 32'h0000_0000);
    for (int p = 0; p < 8; p++) do_read(2'd2, 8'(p * 4), "R4");

    finish_run();
  end
endmodule